// File: doc/BRIEF.md
# Single-Pin Serial Memory Read Sequencer

This block sits on the host side of a serial memory that has a single data pin and three active-low strobes: chip select, output enable and write enable. It takes a burst-read request made of a 16-bit start address and a byte count. It turns the request into a series of single-bit strobe cycles and returns the bytes it reads on a valid/ready stream.

Every access opens with a three-cycle pattern that forces the memory into a known state: a read cycle, then a write cycle carrying 0, then another read cycle. The address follows as sixteen write cycles. Data then comes back as groups of eight read cycles, one group per byte. The memory advances its own address, so the address is sent only once per burst. A closing write cycle carrying 1 returns the memory to standby.

Each bit cycle has the same timing, set by parameters. Chip select falls, a setup interval follows, the chosen strobe is held low for a pulse interval, chip select stays low for a hold interval, and then it stays high for a gap. The protocol is static, so the sequencer can pause with chip select high while a byte waits on the output stream.

Top module: `smem_rd_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, all three strobes are high (1), `mem_io_oe` is 0, `busy` is 0 and `out_valid` is 0.
- R2: A request is taken on a clock edge where `req_valid` is 1 and `busy` is 0. `req_ready` equals the inverse of `busy`. `busy` rises in the cycle after the request is taken and stays high until the closing write cycle has ended. A request presented while `busy` is high is ignored, and so are changes to `req_addr` and `req_len` during that time.
- R3: Every burst begins with a read cycle, then a write cycle whose data bit is 0, then a read cycle.
- R4: After that opening pattern come exactly 16 write cycles carrying the start address, bit 15 first and bit 0 last.
- R5: The burst returns `req_len`+1 bytes. Each byte is built from 8 read cycles, and the first bit read is the byte's most significant bit. `mem_io_in` is sampled on the last clock in which `mem_oe_n` is low.
- R6: Bytes after the first are read with read cycles only. No address bits are sent again, and the memory is relied on to step to the next address and to wrap from FFFF to 0000.
- R7: After the last byte has been accepted on the output stream, the sequencer issues one write cycle carrying 1. `busy` falls on the clock edge that ends the gap of that cycle.
- R8: `mem_oe_n` and `mem_we_n` are never both low.
- R9: `mem_io_oe` is 1 only during write cycles, from the first setup clock through the last hold clock, and it is 0 whenever `mem_oe_n` is low.
- R10: A bit cycle is one clock with every pin idle, then SETUP_CYC clocks with only chip select low, then PULSE_CYC clocks with the strobe low, then HOLD_CYC clocks with only chip select low, then GAP_CYC clocks with chip select high.
- R11: Once `out_valid` rises, it stays high and `out_data` stays unchanged until an edge where `out_ready` is 1. No strobe cycle runs while a byte is waiting. Once the byte is taken, the next bit cycle starts with its idle clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 16 | Start address of the burst |
| req_len | input | 8 | Number of bytes minus one |
| busy | output | 1 | Burst in progress |
| out_valid | output | 1 | A received byte is waiting |
| out_ready | input | 1 | Consumer takes the waiting byte |
| out_data | output | 8 | Received byte |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_io_out | output | 1 | Bit driven onto the data pin |
| mem_io_oe | output | 1 | Host drives the data pin when 1 |
| mem_io_in | input | 1 | Level seen on the data pin |

## Verification
A new request can arrive in the same cycle that the closing write cycle of the previous burst finishes its gap. At that moment `busy` is still high, so the request has to be refused. It must then be taken on the very next edge, with exactly one idle cycle between the two bursts. The bench creates this case by raising `req_valid` early in a burst, with a different address, and holding it there. A clock-by-clock model predicts the refusal, the single idle cycle and the address that is then sent, and the output pins are compared against that model on every clock. A second overlap happens when a byte handoff is held back by `out_ready` at the point where the next read cycle would otherwise begin. That case is produced by a stall pattern on `out_ready` and is judged in the same way.

// File: rtl/smem_pkg.sv
package smem_pkg;

    typedef enum logic [2:0] {
        EP_IDLE,
        EP_SETUP,
        EP_PULSE,
        EP_HOLD,
        EP_GAP
    } eng_phase_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SYNC_RD0,
        SQ_SYNC_WR0,
        SQ_SYNC_RD1,
        SQ_ADDR,
        SQ_DATA,
        SQ_HAND,
        SQ_STOP
    } seq_state_e;

    typedef struct packed {
        logic wr;
        logic dbit;
    } cyc_cmd_t;

    function automatic eng_phase_e next_phase(input eng_phase_e p);
        case (p)
            EP_SETUP: return EP_PULSE;
            EP_PULSE: return EP_HOLD;
            EP_HOLD:  return EP_GAP;
            default:  return EP_IDLE;
        endcase
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/smem_strobe_engine.sv
module smem_strobe_engine
    import smem_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 2,
    parameter int HOLD_CYC  = 1,
    parameter int GAP_CYC   = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     go,
    input  cyc_cmd_t cmd,
    input  logic     io_in,
    output logic     done,
    output logic     rx_bit,
    output logic     ce_n,
    output logic     oe_n,
    output logic     we_n,
    output logic     io_oe,
    output logic     io_out
);
    localparam int MAXC = max4(SETUP_CYC, PULSE_CYC, HOLD_CYC, GAP_CYC);
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

    eng_phase_e phase;
    logic [CW-1:0] cnt;
    cyc_cmd_t cmd_q;
    logic rx_q;
    int phase_len;
    logic last;
    logic active;

    always_comb begin
        case (phase)
            EP_SETUP: phase_len = SETUP_CYC;
            EP_PULSE: phase_len = PULSE_CYC;
            EP_HOLD:  phase_len = HOLD_CYC;
            EP_GAP:   phase_len = GAP_CYC;
            default:  phase_len = 1;
        endcase
    end

    assign last = (cnt == CW'(phase_len - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= EP_IDLE;
            cnt   <= '0;
            cmd_q <= '0;
            rx_q  <= 1'b0;
        end else if (phase == EP_IDLE) begin
            cnt <= '0;
            if (go) begin
                phase <= EP_SETUP;
                cmd_q <= cmd;
            end
        end else begin
            if (phase == EP_PULSE && last && !cmd_q.wr) begin
                rx_q <= io_in;
            end
            if (last) begin
                phase <= next_phase(phase);
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign active = (phase == EP_SETUP) || (phase == EP_PULSE) || (phase == EP_HOLD);
    assign done   = (phase == EP_GAP) && last;
    assign rx_bit = rx_q;
    assign ce_n   = !active;
    assign oe_n   = !((phase == EP_PULSE) && !cmd_q.wr);
    assign we_n   = !((phase == EP_PULSE) && cmd_q.wr);
    assign io_oe  = active && cmd_q.wr;
    assign io_out = cmd_q.dbit;

    // R10: a strobe only falls after chip select has been low for a clock
    p_ce_setup_r10: assert property (@(posedge clk) disable iff (rst)
        ($fell(oe_n) || $fell(we_n)) |-> $past(!ce_n));
    // R10: chip select is still low on the clock a strobe rises
    p_ce_hold_r10: assert property (@(posedge clk) disable iff (rst)
        ($rose(oe_n) || $rose(we_n)) |-> !ce_n);
    // R8: the two strobes never fall together
    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(!oe_n && !we_n));
    // R9: the host never drives the pin while the memory may drive it
    p_no_contention_r9: assert property (@(posedge clk) disable iff (rst)
        io_oe |-> oe_n);

endmodule

// File: rtl/smem_shift_path.sv
module smem_shift_path #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              addr_shift,
    output logic              addr_msb,
    input  logic              rx_shift,
    input  logic              rx_bit,
    input  logic              capture,
    output logic [DATA_W-1:0] byte_out
);
    logic [ADDR_W-1:0] addr_sr;
    logic [DATA_W-2:0] rx_sr;
    logic [DATA_W-1:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_sr <= '0;
            rx_sr   <= '0;
            byte_q  <= '0;
        end else begin
            if (load) begin
                addr_sr <= addr_in;
            end else if (addr_shift) begin
                addr_sr <= {addr_sr[ADDR_W-2:0], 1'b0};
            end
            if (rx_shift) begin
                rx_sr <= {rx_sr[DATA_W-3:0], rx_bit};
            end
            if (capture) begin
                byte_q <= {rx_sr, rx_bit};
            end
        end
    end

    assign addr_msb = addr_sr[ADDR_W-1];
    assign byte_out = byte_q;

endmodule

// File: rtl/smem_seq_fsm.sv
module smem_seq_fsm
    import smem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [LEN_W-1:0] req_len,
    output logic             req_take,
    output logic             busy,
    input  logic             cyc_done,
    output logic             cyc_go,
    output cyc_cmd_t         cyc_cmd,
    input  logic             addr_msb,
    output logic             addr_shift,
    output logic             rx_shift,
    output logic             capture,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             in_data_phase
);
    localparam int BW = $clog2(ADDR_W);

    seq_state_e st;
    logic pend;
    logic [BW-1:0] bcnt;
    logic [LEN_W-1:0] left;
    logic valid_q;
    logic op;

    assign op = (st != SQ_IDLE) && (st != SQ_HAND);
    assign busy = (st != SQ_IDLE);
    assign req_take = (st == SQ_IDLE) && req_valid;
    assign cyc_go = op && !pend;
    assign in_data_phase = (st == SQ_DATA);
    assign out_valid = valid_q;

    always_comb begin
        cyc_cmd = '0;
        case (st)
            SQ_SYNC_WR0: cyc_cmd = '{wr: 1'b1, dbit: 1'b0};
            SQ_ADDR:     cyc_cmd = '{wr: 1'b1, dbit: addr_msb};
            SQ_STOP:     cyc_cmd = '{wr: 1'b1, dbit: 1'b1};
            default:     cyc_cmd = '{wr: 1'b0, dbit: 1'b0};
        endcase
    end

    assign addr_shift = (st == SQ_ADDR) && cyc_done;
    assign rx_shift   = (st == SQ_DATA) && cyc_done;
    assign capture    = rx_shift && (bcnt == BW'(DATA_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            pend    <= 1'b0;
            bcnt    <= '0;
            left    <= '0;
            valid_q <= 1'b0;
        end else begin
            if (cyc_go) begin
                pend <= 1'b1;
            end else if (cyc_done) begin
                pend <= 1'b0;
            end
            case (st)
                SQ_IDLE: begin
                    if (req_valid) begin
                        st   <= SQ_SYNC_RD0;
                        left <= req_len;
                        bcnt <= '0;
                    end
                end
                SQ_SYNC_RD0: if (cyc_done) st <= SQ_SYNC_WR0;
                SQ_SYNC_WR0: if (cyc_done) st <= SQ_SYNC_RD1;
                SQ_SYNC_RD1: begin
                    if (cyc_done) begin
                        st   <= SQ_ADDR;
                        bcnt <= '0;
                    end
                end
                SQ_ADDR: begin
                    if (cyc_done) begin
                        if (bcnt == BW'(ADDR_W - 1)) begin
                            st   <= SQ_DATA;
                            bcnt <= '0;
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                end
                SQ_DATA: begin
                    if (cyc_done) begin
                        if (bcnt == BW'(DATA_W - 1)) begin
                            st      <= SQ_HAND;
                            bcnt    <= '0;
                            valid_q <= 1'b1;
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                end
                SQ_HAND: begin
                    if (out_ready) begin
                        valid_q <= 1'b0;
                        if (left == '0) begin
                            st <= SQ_STOP;
                        end else begin
                            left <= left - 1'b1;
                            st   <= SQ_DATA;
                        end
                    end
                end
                SQ_STOP: if (cyc_done) st <= SQ_IDLE;
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // R11: a waiting byte is held until the consumer takes it
    p_hold_until_ready_r11: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !out_ready) |=> valid_q);
    // R7: a burst ends only after the stop cycle has finished
    p_idle_after_stop_r7: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_IDLE && $past(st) != SQ_IDLE) |-> $past(st) == SQ_STOP);
    // R2: the sequencer leaves idle only on a request
    p_start_on_req_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));

endmodule

// File: rtl/smem_rd_seq.sv
module smem_rd_seq
    import smem_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int LEN_W     = 8,
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 2,
    parameter int HOLD_CYC  = 1,
    parameter int GAP_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              busy,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_io_out,
    output logic              mem_io_oe,
    input  logic              mem_io_in
);
    logic req_take;
    logic cyc_go;
    logic cyc_done;
    cyc_cmd_t cyc_cmd;
    logic rx_bit;
    logic addr_msb;
    logic addr_shift;
    logic rx_shift;
    logic capture;
    logic in_data_phase;

    assign req_ready = !busy;

    smem_seq_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)
    ) u_fsm (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_len(req_len), .req_take(req_take),
        .busy(busy),
        .cyc_done(cyc_done), .cyc_go(cyc_go), .cyc_cmd(cyc_cmd),
        .addr_msb(addr_msb), .addr_shift(addr_shift),
        .rx_shift(rx_shift), .capture(capture),
        .out_valid(out_valid), .out_ready(out_ready),
        .in_data_phase(in_data_phase)
    );

    smem_shift_path #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_path (
        .clk(clk), .rst(rst),
        .load(req_take), .addr_in(req_addr),
        .addr_shift(addr_shift), .addr_msb(addr_msb),
        .rx_shift(rx_shift), .rx_bit(rx_bit),
        .capture(capture), .byte_out(out_data)
    );

    smem_strobe_engine #(
        .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
        .HOLD_CYC(HOLD_CYC), .GAP_CYC(GAP_CYC)
    ) u_eng (
        .clk(clk), .rst(rst),
        .go(cyc_go), .cmd(cyc_cmd), .io_in(mem_io_in),
        .done(cyc_done), .rx_bit(rx_bit),
        .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
        .io_oe(mem_io_oe), .io_out(mem_io_out)
    );

    // R6: once data is flowing, no write strobe reaches the memory
    p_data_reads_only_r6: assert property (@(posedge clk) disable iff (rst)
        in_data_phase |-> mem_we_n);
    // R11: the memory is left idle while a byte waits
    p_quiet_while_waiting_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> mem_ce_n);
    // R11: the waiting byte does not change before it is taken
    p_data_stable_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(out_data));

endmodule

// File: tb/smem_rd_seq_bench.sv
`timescale 1ns/1ps
module smem_rd_seq_bench;
    localparam int SU = 1;
    localparam int PW = 2;
    localparam int HD = 1;
    localparam int GP = 1;

    logic clk = 1'b0;
    logic rst;
    logic req_valid;
    logic req_ready;
    logic [15:0] req_addr;
    logic [7:0] req_len;
    logic busy;
    logic out_valid;
    logic out_ready;
    logic [7:0] out_data;
    logic mem_ce_n, mem_oe_n, mem_we_n, mem_io_out, mem_io_oe, mem_io_in;

    always #10 clk = ~clk;

    smem_rd_seq #(
        .SETUP_CYC(SU), .PULSE_CYC(PW), .HOLD_CYC(HD), .GAP_CYC(GP)
    ) u_smem_rd_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .busy(busy),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_io_out(mem_io_out), .mem_io_oe(mem_io_oe), .mem_io_in(mem_io_in)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    bit live = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, expv, $time);
        end
    endtask

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    // ---------------- memory responder ----------------
    typedef enum int {D_STBY, D_ADDR, D_DATA} dev_e;
    dev_e d_state = D_STBY;
    logic [15:0] d_addr = '0;
    int d_acnt = 0;
    int d_bit = 0;
    int p1 = 0, p2 = 0; // 1 read, 2 write0, 3 write1
    logic prev_oe = 1'b1, prev_we = 1'b1;
    logic cur_bit;

    always_comb begin
        logic [7:0] v;
        v = memf(d_addr);
        cur_bit = (d_state == D_DATA) ? v[7 - d_bit] : 1'b1;
    end
    assign mem_io_in = (!mem_ce_n && !mem_oe_n) ? cur_bit : 1'b1;

    always @(negedge clk) begin
        if (rst) begin
            d_state = D_STBY; p1 = 0; p2 = 0;
        end else begin
            if (!prev_oe && mem_oe_n) begin
                if (d_state == D_DATA) begin
                    d_bit++;
                    if (d_bit == 8) begin d_bit = 0; d_addr = d_addr + 16'd1; end
                end
                if (p2 == 1 && p1 == 2) begin d_state = D_ADDR; d_acnt = 0; end
                p2 = p1; p1 = 1;
            end
            if (!prev_we && mem_we_n) begin
                if (d_state == D_ADDR) begin
                    d_addr = {d_addr[14:0], mem_io_out};
                    d_acnt++;
                    if (d_acnt == 16) begin d_state = D_DATA; d_bit = 0; end
                end else if (mem_io_out) begin
                    d_state = D_STBY;
                end
                p2 = p1; p1 = mem_io_out ? 3 : 2;
            end
        end
        prev_oe = mem_oe_n;
        prev_we = mem_we_n;
    end

    // ---------------- clock-by-clock reference model ----------------
    logic e_ce = 1, e_oe = 1, e_we = 1, e_ioe = 0, e_io = 0;
    logic e_busy = 0, e_valid = 0;
    logic [7:0] e_data = '0;
    string e_tag = "R1";
    bit m_busy = 0;

    task automatic bitcyc(input bit wr, input bit b, input string tag);
        int total;
        total = 1 + SU + PW + HD + GP;
        e_tag = tag;
        for (int k = 0; k < total; k++) begin
            e_io = b;
            if (k == 0 || k > SU + PW + HD) begin
                e_ce = 1; e_oe = 1; e_we = 1; e_ioe = 0;
            end else if (k <= SU || k > SU + PW) begin
                e_ce = 0; e_oe = 1; e_we = 1; e_ioe = wr;
            end else begin
                e_ce = 0; e_oe = wr; e_we = !wr; e_ioe = wr;
            end
            @(posedge clk); #1;
        end
        e_ce = 1; e_oe = 1; e_we = 1; e_ioe = 0;
    endtask

    task automatic handoff(input logic [7:0] d, input string tag);
        bit r;
        e_tag = tag;
        e_valid = 1; e_data = d;
        forever begin
            @(posedge clk);
            r = out_ready;
            #1;
            if (r) break;
        end
        e_valid = 0;
    endtask

    task automatic run_txn(input logic [15:0] a, input logic [7:0] len);
        m_busy = 1; e_busy = 1;
        bitcyc(0, 0, "R3");
        bitcyc(1, 0, "R3");
        bitcyc(0, 0, "R3");
        for (int i = 15; i >= 0; i--) bitcyc(1, a[i], "R4");
        for (int n = 0; n <= int'(len); n++) begin
            for (int j = 0; j < 8; j++) bitcyc(0, 0, (n == 0) ? "R5" : "R6");
            handoff(memf(a + 16'(n)), (n == 0) ? "R5" : "R6");
        end
        bitcyc(1, 1, "R7");
        m_busy = 0; e_busy = 0;
    endtask

    initial begin
        bit acc;
        logic [15:0] la;
        logic [7:0] ll;
        forever begin
            @(posedge clk);
            acc = !rst && req_valid && !m_busy;
            la = req_addr; ll = req_len;
            #1;
            if (acc) run_txn(la, ll);
        end
    end

    always @(negedge clk) begin
        if (live && !rst && !finished) begin
            chk(mem_ce_n == e_ce, "R10", "ce_n", mem_ce_n, e_ce);
            chk({mem_oe_n, mem_we_n} == {e_oe, e_we}, e_tag, "oe_n/we_n",
                {mem_oe_n, mem_we_n}, {e_oe, e_we});
            chk(!(!mem_oe_n && !mem_we_n), "R8", "strobe overlap",
                {mem_oe_n, mem_we_n}, 2'b11);
            chk(mem_io_oe == e_ioe, "R9", "io_oe", mem_io_oe, e_ioe);
            if (e_ioe) chk(mem_io_out == e_io, e_tag, "io_out", mem_io_out, e_io);
            chk(busy == e_busy, "R2", "busy", busy, e_busy);
            chk(req_ready == !e_busy, "R2", "req_ready", req_ready, !e_busy);
            chk(out_valid == e_valid, "R11", "out_valid", out_valid, e_valid);
            if (e_valid) chk(out_data == e_data, e_tag, "out_data", out_data, e_data);
        end
    end

    // ---------------- out_ready pattern ----------------
    bit stall = 0;
    int rcnt = 0;
    always @(negedge clk) begin
        if (stall) begin
            out_ready <= (rcnt % 3 == 2);
            rcnt++;
        end else begin
            out_ready <= 1'b1;
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input logic [15:0] a, input logic [7:0] l);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_len = l;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        rst = 1; req_valid = 0; req_addr = '0; req_len = '0; out_ready = 1;
        repeat (3) @(negedge clk);
        chk({mem_ce_n, mem_oe_n, mem_we_n} == 3'b111, "R1", "strobes in reset",
            {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        chk(!mem_io_oe && !busy && !out_valid, "R1", "io_oe/busy/valid in reset",
            {mem_io_oe, busy, out_valid}, 0);
        rst = 0;
        @(negedge clk);
        chk({mem_ce_n, mem_oe_n, mem_we_n, mem_io_oe, busy, out_valid} == 6'b111000,
            "R1", "first cycle after reset",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_io_oe, busy, out_valid}, 6'b111000);
        live = 1;

        issue(16'h1234, 8'd0);                // R3 R4 R5 R7 single byte
        wait_idle();

        stall = 1;                            // R11 backpressure, R6 follow-on bytes
        issue(16'h00FF, 8'd2);
        wait_idle();
        stall = 0;

        issue(16'hFFFF, 8'd1);                // R6 wrap to 0000
        wait_idle();

        issue(16'h4000, 8'd0);                // R2 request held across busy drop
        @(negedge clk);
        req_valid = 1; req_addr = 16'hABCD; req_len = 8'd1;
        do @(negedge clk); while (!req_ready);
        @(negedge clk);
        chk(busy == 1'b1, "R2", "busy after single idle cycle", busy, 1);
        req_valid = 0; req_addr = 16'h5555;
        wait_idle();

        finished = 1;
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected done");
            summary();
        end
    end

endmodule